// File: doc/BRIEF.md
# Cuckoo Hash Exact-Match Lookup Engine

This block answers exact-match queries on a fixed-width key. Two hash tables, each of `T` slots, hold records made of a valid bit, a key and a data word. Every cycle a new key may be presented with a sideband tag. Both tables are read at their own hash index, and a single spare register called the park register is read as well. The key is compared against all three records at once. One cycle later the engine returns the tag, a found flag and the data of the record that matched.

Each table index is the low `IDX_W` bits of an 8-bit CRC of the key. The CRC is taken MSB first from a zero seed. Table 0 uses polynomial `POLY0` and table 1 uses `POLY1`, so one key lands at different places in the two tables. Key-set changes arrive one at a time on a configuration port. A delete clears the valid bit of the matching record. An insert of a key that is already present overwrites its data. An insert of a new key first goes into the park register. From there the controller walks a chain of evictions that alternates between the tables. At each step the parked record is swapped with the occupant of its slot, until an empty slot takes it. Lookups keep running the whole time, and every key in the set stays visible in a table or in the park register. The engine holds at most `2*T+1` records.

Top module: `cuckoo_lookup`

## Requirements
- R1: After reset no record is valid, `res_valid` and `cfg_rsp_valid` are 0, `cfg_ready` is 1 and `ins_blocked` is 0.
- R2: A lookup presented with `lk_valid` at a clock edge produces `res_valid`=1 and the same `res_tag` after that edge. With `lk_valid`=0, `res_valid` is 0 after the edge.
- R3: A lookup of a key in the active set returns `res_found`=1 and that key's current data. This holds whether the record sits in a table or in the park register.
- R4: A lookup of a key outside the active set returns `res_found`=0, including a key whose record was deleted. An invalid slot never matches, and at most one record matches.
- R5: A new key whose insert was accepted at an edge is found by every lookup presented from the next edge on. No key already in the set stops being found while evictions move records.
- R6: An insert (`cfg_op`=0) of a key already present replaces its data and answers `cfg_rsp_ok`=1 one cycle after acceptance.
- R7: A delete (`cfg_op`=1) of a present key removes it and answers `cfg_rsp_ok`=1 one cycle later. A delete of an absent key answers `cfg_rsp_ok`=0 and leaves every lookup result unchanged.
- R8: Each accepted request produces exactly one `cfg_rsp_valid` pulse. `cfg_ready` is low while an eviction chain runs.
- R9: An eviction chain stops after `MAX_KICKS` swaps. It then answers `cfg_rsp_ok`=0 and keeps the last displaced record searchable in the park register, so every key stays found, and it raises `ins_blocked`.
- R10: While `ins_blocked` is high, an insert of a new key answers `cfg_rsp_ok`=0 one cycle later and the key is not added. The set never holds more than `2*T+1` keys.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup key present this cycle |
| lk_key | input | KEY_W | Key to search |
| lk_tag | input | TAG_W | Sideband tag carried to the result |
| res_valid | output | 1 | Result present |
| res_found | output | 1 | Key was matched |
| res_data | output | DATA_W | Data of matched record |
| res_tag | output | TAG_W | Tag of the lookup this result answers |
| cfg_valid | input | 1 | Configuration request present |
| cfg_op | input | 1 | 0 insert, 1 delete |
| cfg_key | input | KEY_W | Key of the request |
| cfg_data | input | DATA_W | Data for an insert |
| cfg_ready | output | 1 | Controller idle, request accepted when valid |
| cfg_rsp_valid | output | 1 | One-cycle response pulse |
| cfg_rsp_ok | output | 1 | Insert placed or updated, or delete hit |
| ins_blocked | output | 1 | Park register holds a record after a failed chain |

## Verification
The bench runs lookups on almost every cycle while inserts push records through eviction chains. A design that dropped the in-transit record from the compare, or that let a swap open a gap, would report a present key as missing in the middle of a chain. The bench then fills the engine until a chain gives up. A design that lost the last displaced record, or that still took new keys afterwards, would show a missing key or an extra one in the set. Overwrites, deletes of missing keys and lookups of deleted keys are aimed at comparators that ignore the valid bit and at delete paths that touch other records.

// File: rtl/cuckoo_lookup.sv
module cuckoo_lookup #(
  parameter int KEY_W = 16,
  parameter int DATA_W = 16,
  parameter int TAG_W = 4,
  parameter int IDX_W = 3,
  parameter int MAX_KICKS = 8,
  parameter logic [7:0] POLY0 = 8'h07,
  parameter logic [7:0] POLY1 = 8'h1D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [KEY_W-1:0]  lk_key,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              res_valid,
  output logic              res_found,
  output logic [DATA_W-1:0] res_data,
  output logic [TAG_W-1:0]  res_tag,
  input  logic              cfg_valid,
  input  logic              cfg_op,
  input  logic [KEY_W-1:0]  cfg_key,
  input  logic [DATA_W-1:0] cfg_data,
  output logic              cfg_ready,
  output logic              cfg_rsp_valid,
  output logic              cfg_rsp_ok,
  output logic              ins_blocked
);
  localparam int T = 1 << IDX_W;
  localparam int KC_W = $clog2(MAX_KICKS + 1);

  function automatic logic [IDX_W-1:0] hidx(input logic [KEY_W-1:0] k, input logic [7:0] poly);
    logic [7:0] c;
    logic fb;
    c = 8'h00;
    for (int i = KEY_W - 1; i >= 0; i--) begin
      fb = c[7] ^ k[i];
      c = {c[6:0], 1'b0};
      if (fb) c = c ^ poly;
    end
    return c[IDX_W-1:0];
  endfunction

  logic [KEY_W-1:0]  tk [2][T];
  logic [DATA_W-1:0] td [2][T];
  logic              tv [2][T];
  logic              pv;
  logic [KEY_W-1:0]  pk;
  logic [DATA_W-1:0] pd;
  logic              kicking, ktab;
  logic [KC_W-1:0]   kicks;

  logic [IDX_W-1:0] li0, li1, ci0, ci1, kidx;
  logic lh0, lh1, lhp, ch0, ch1, chp;

  assign li0 = hidx(lk_key, POLY0);
  assign li1 = hidx(lk_key, POLY1);
  assign lh0 = tv[0][li0] && tk[0][li0] == lk_key;
  assign lh1 = tv[1][li1] && tk[1][li1] == lk_key;
  assign lhp = pv && pk == lk_key;

  assign ci0 = hidx(cfg_key, POLY0);
  assign ci1 = hidx(cfg_key, POLY1);
  assign ch0 = tv[0][ci0] && tk[0][ci0] == cfg_key;
  assign ch1 = tv[1][ci1] && tk[1][ci1] == cfg_key;
  assign chp = pv && pk == cfg_key;

  assign kidx = ktab ? hidx(pk, POLY1) : hidx(pk, POLY0);
  assign cfg_ready = !kicking;
  assign ins_blocked = pv && !kicking;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < T; i++) begin
          tv[b][i] <= 1'b0;
          tk[b][i] <= '0;
          td[b][i] <= '0;
        end
      pv <= 1'b0; pk <= '0; pd <= '0;
      kicking <= 1'b0; ktab <= 1'b0; kicks <= '0;
      res_valid <= 1'b0; res_found <= 1'b0; res_data <= '0; res_tag <= '0;
      cfg_rsp_valid <= 1'b0; cfg_rsp_ok <= 1'b0;
    end else begin
      res_valid <= lk_valid;
      res_tag   <= lk_tag;
      res_found <= lh0 | lh1 | lhp;
      res_data  <= lh0 ? td[0][li0] : lh1 ? td[1][li1] : lhp ? pd : '0;
      cfg_rsp_valid <= 1'b0;
      if (!kicking) begin
        if (cfg_valid) begin
          cfg_rsp_valid <= 1'b1;
          if (cfg_op) begin
            if (ch0) tv[0][ci0] <= 1'b0;
            if (ch1) tv[1][ci1] <= 1'b0;
            if (chp) pv <= 1'b0;
            cfg_rsp_ok <= ch0 | ch1 | chp;
          end else if (ch0 | ch1 | chp) begin
            if (ch0) td[0][ci0] <= cfg_data;
            if (ch1) td[1][ci1] <= cfg_data;
            if (chp) pd <= cfg_data;
            cfg_rsp_ok <= 1'b1;
          end else if (pv) begin
            cfg_rsp_ok <= 1'b0;
          end else begin
            cfg_rsp_valid <= 1'b0;
            pv <= 1'b1; pk <= cfg_key; pd <= cfg_data;
            ktab <= 1'b0; kicks <= '0; kicking <= 1'b1;
          end
        end
      end else if (!tv[ktab][kidx]) begin
        tv[ktab][kidx] <= 1'b1;
        tk[ktab][kidx] <= pk;
        td[ktab][kidx] <= pd;
        pv <= 1'b0;
        kicking <= 1'b0;
        cfg_rsp_valid <= 1'b1;
        cfg_rsp_ok <= 1'b1;
      end else begin
        tk[ktab][kidx] <= pk;
        td[ktab][kidx] <= pd;
        pk <= tk[ktab][kidx];
        pd <= td[ktab][kidx];
        ktab <= !ktab;
        kicks <= kicks + 1'b1;
        if (kicks == KC_W'(MAX_KICKS - 1)) begin
          kicking <= 1'b0;
          cfg_rsp_valid <= 1'b1;
          cfg_rsp_ok <= 1'b0;
        end
      end
    end
  end

  p_one_match_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({lh0, lh1, lhp}));
  p_result_follows_r2: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> res_valid);
  p_no_result_r2: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !res_valid);
  p_transit_held_r5: assert property (@(posedge clk) disable iff (rst)
    kicking |-> pv);
  p_kick_bound_r9: assert property (@(posedge clk) disable iff (rst)
    kicks <= KC_W'(MAX_KICKS));
  p_fail_parks_r9: assert property (@(posedge clk) disable iff (rst)
    (kicking && tv[ktab][kidx] && kicks == KC_W'(MAX_KICKS - 1)) |=> (ins_blocked && cfg_rsp_valid && !cfg_rsp_ok));
  p_busy_silent_r8: assert property (@(posedge clk) disable iff (rst)
    (kicking && $past(kicking)) |-> !cfg_rsp_valid);
endmodule

// File: tb/cuckoo_lookup_bench.sv
module cuckoo_lookup_bench;
  localparam int KW = 16, DW = 16, TW = 4;
  localparam int CAP = 2 * 8 + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lk_valid = 1'b0;
  logic [KW-1:0] lk_key = '0;
  logic [TW-1:0] lk_tag = '0;
  logic res_valid, res_found;
  logic [DW-1:0] res_data;
  logic [TW-1:0] res_tag;
  logic cfg_valid = 1'b0, cfg_op = 1'b0;
  logic [KW-1:0] cfg_key = '0;
  logic [DW-1:0] cfg_data = '0;
  logic cfg_ready, cfg_rsp_valid, cfg_rsp_ok, ins_blocked;

  cuckoo_lookup u_cuckoo_lookup (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_key(lk_key), .lk_tag(lk_tag),
    .res_valid(res_valid), .res_found(res_found), .res_data(res_data), .res_tag(res_tag),
    .cfg_valid(cfg_valid), .cfg_op(cfg_op), .cfg_key(cfg_key), .cfg_data(cfg_data),
    .cfg_ready(cfg_ready), .cfg_rsp_valid(cfg_rsp_valid), .cfg_rsp_ok(cfg_rsp_ok),
    .ins_blocked(ins_blocked)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  bit [DW-1:0] mdl [int];
  bit mstuck = 0;
  bit ex_v = 0, ex_f = 0;
  bit [DW-1:0] ex_d = '0;
  bit [TW-1:0] ex_t = '0;
  bit rsp_pend = 0, rsp_known = 0, rsp_exp = 0;

  function automatic bit [KW-1:0] pool(input int i);
    if (i >= 40) return (i == 40) ? 16'h0000 : 16'hBEEF;
    return KW'(i * 37 + 5);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    int k;
    ex_v = lk_valid;
    ex_t = lk_tag;
    k = int'(lk_key);
    ex_f = mdl.exists(k);
    ex_d = ex_f ? mdl[k] : '0;
    if (cfg_valid && cfg_ready) begin
      k = int'(cfg_key);
      rsp_pend = 1;
      rsp_known = 1;
      if (cfg_op) begin
        rsp_exp = mdl.exists(k);
        if (rsp_exp) mdl.delete(k);
      end else if (mdl.exists(k)) begin
        mdl[k] = cfg_data; rsp_exp = 1;
      end else if (mstuck) begin
        rsp_exp = 0;
      end else begin
        mdl[k] = cfg_data; rsp_known = 0;
      end
    end
    @(negedge clk);
    cycles++;
    if (ex_v) begin
      chk(res_valid && res_tag == ex_t, "R2 tag", int'(res_tag), int'(ex_t));
      chk(res_found == ex_f, ex_f ? "R3/R5 found" : "R4 absent", int'(res_found), int'(ex_f));
      if (ex_f) chk(res_data == ex_d, "R3 data", int'(res_data), int'(ex_d));
    end else chk(!res_valid, "R2 idle", int'(res_valid), 0);
    if (cfg_rsp_valid) begin
      chk(rsp_pend, "R8 extra response", 1, 0);
      if (rsp_pend && rsp_known) chk(cfg_rsp_ok == rsp_exp, "R6/R7/R10 rsp_ok", int'(cfg_rsp_ok), int'(rsp_exp));
      if (rsp_pend && !rsp_known && !cfg_rsp_ok) mstuck = 1;
      rsp_pend = 0;
    end
    chk(ins_blocked == mstuck, "R9 ins_blocked", int'(ins_blocked), int'(mstuck));
    lk_valid = ($urandom_range(0, 7) != 0);
    lk_key = pool($urandom_range(0, 41));
    lk_tag = TW'($urandom);
  endtask

  task automatic do_cfg(input bit op, input int key, input int data);
    int n = 0;
    while (!cfg_ready) tick();
    cfg_valid = 1; cfg_op = op; cfg_key = KW'(key); cfg_data = DW'(data);
    tick();
    cfg_valid = 0;
    while (rsp_pend && n < 100) begin tick(); n++; end
    if (rsp_pend) begin chk(0, "R8 no response", 0, 1); rsp_pend = 0; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(cfg_ready && !cfg_rsp_valid && !res_valid && !ins_blocked, "R1 reset", 0, 1);
    for (int i = 0; i < 6; i++) tick();
    for (int i = 0; i < 6; i++) do_cfg(0, int'(pool(i)), 16'h100 + i);
    for (int i = 0; i < 12; i++) tick();
    do_cfg(0, int'(pool(2)), 16'hA5A5);
    do_cfg(1, int'(pool(3)), 0);
    do_cfg(1, int'(pool(3)), 0);
    do_cfg(1, 16'hBEEF, 0);
    for (int i = 0; i < 12; i++) tick();
    do_cfg(0, int'(pool(40)), 16'h7777);
    for (int i = 6; i < 40 && !mstuck; i++) do_cfg(0, int'(pool(i)), 16'h200 + i);
    chk(mstuck, "R9 chain gave up", int'(mstuck), 1);
    chk(mdl.num() <= CAP, "R10 capacity", mdl.num(), CAP);
    do_cfg(0, 16'hBEEF, 16'h1234);
    do_cfg(0, int'(pool(40)), 16'h4321);
    for (int i = 0; i < 42; i++) begin
      lk_valid = 1; lk_key = pool(i); lk_tag = TW'(i);
      tick();
    end
    tick();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=done", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule